// File: doc/BRIEF.md
# Dual External Interrupt Request Conditioner

This block takes two active-low external interrupt pins that share one CPU interrupt vector and turns them into a single registered request line. Each pin is first passed through a synchronizer. A per-pin trigger select then decides how the pin is judged. In low-level mode, the request follows the pin for as long as it is held low. In falling-edge mode, one edge is captured and held until it is serviced.

Software sees the block through two byte-wide registers. The control register holds a per-pin enable and a per-pin trigger select. The status register shows each pin's pending condition, and writing 1 to a status bit clears that pin's captured edge. The request to the CPU is blocked while the global interrupt mask input is high. When the CPU fetches the shared vector, it pulses an acknowledge input, and this acknowledge drops every captured edge.

Top module: `xirq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_req_o` is 0. The control register reads 0, meaning both pins are disabled and in level mode. The status register reads 0.
- R2: In the control register (address 0), bit i is the enable of pin i and bit 4+i is the trigger select of pin i (0 = low level, 1 = falling edge). All other bits read 0, and a write followed by a read returns the written value masked to these bits.
- R3: In level mode, an enabled pin held low while the mask is clear asserts the request. The request stays asserted across a vector acknowledge for as long as the pin remains low, and it drops once the pin returns high.
- R4: In level mode, a low pulse that begins and ends while the mask is set leaves nothing pending, so no request appears when the mask is later cleared.
- R5: In edge mode, a falling edge on an enabled pin asserts the request. After the acknowledge, a pin that stays low does not assert it again.
- R6: In edge mode, a falling edge seen while the mask is set is held and raises the request as soon as the mask clears. Two masked edges on one pin yield a single request.
- R7: The status register (address 1) shows pin i's pending condition in bit i. Writing 1 to bit i clears only pin i's held edge. The vector acknowledge clears the held edges of all pins. A falling edge that arrives in the same cycle as such a clear stays held.
- R8: While the mask input is high, `irq_req_o` is 0 on the following cycle, even when a pin is pending.
- R9: A pending condition on a disabled pin shows in the status register but does not assert the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n_i | input | NPIN | Active-low external interrupt pins (asynchronous) |
| imask_i | input | 1 | Global interrupt mask; 1 blocks the request |
| vec_ack_i | input | 1 | One-cycle pulse when the CPU fetches the shared vector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Registered read data for the address of the previous cycle |
| irq_req_o | output | 1 | Registered interrupt request to the CPU |

## Verification
All latencies below count rising clock edges, starting from the edge that first samples a change.

- A low level on a pin reaches both the request and the status read data on the third edge. A falling edge in edge mode reaches them on the fourth edge, because the held edge adds one more register.
- A change on the mask input, and the clearing of a held edge, show at the outputs one edge after they are sampled.
- A register write is visible in the read data one edge after the write edge.

The driver changes inputs on falling edges and pushes an expected item for one chosen rising edge. The monitor samples a quarter period after each rising edge, so every comparison lands exactly on the cycle derived from these counts. The same-cycle clear case is timed so that the status write is sampled on the same edge that captures the falling edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned MODE_LSB = 4;   // trigger selects start here in control
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '1;
    else     chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '1;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_pin.sv
module xirq_pin
  import xirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  lvl_i,     // synchronized pin level
  input  trig_e mode_i,
  input  logic  ack_i,     // vector fetch
  input  logic  clr_i,     // write-one-clear from status
  output logic  fall_o,
  output logic  pend_o
);
  logic prev_q;
  logic held_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;

  always_ff @(posedge clk) begin
    if (rst || mode_i == TRIG_LEVEL) held_q <= 1'b0;
    else if (fall_o)                 held_q <= 1'b1;   // new edge wins over clear
    else if (ack_i || clr_i)         held_q <= 1'b0;
  end

  assign pend_o = (mode_i == TRIG_EDGE) ? held_q : ~lvl_i;
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned NPIN = 2,
  parameter int unsigned DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic            addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NPIN-1:0] pend_i,
  output logic [NPIN-1:0] en_o,
  output trig_e           mode_o [NPIN],
  output logic [NPIN-1:0] clr_o,
  output logic            ctrl_wr_o,
  output logic [DW-1:0]   rdata_o
);
  logic [NPIN-1:0] en_q;
  logic [NPIN-1:0] mode_q;
  logic [DW-1:0]   rdata_q;
  logic [DW-1:0]   ctrl_img;
  logic [DW-1:0]   stat_img;
  logic            unused_wbits;

  assign ctrl_wr_o    = wr_i && (addr_i == ADDR_CTRL);
  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= '0;
    end else if (ctrl_wr_o) begin
      en_q   <= wdata_i[NPIN-1:0];
      mode_q <= wdata_i[MODE_LSB +: NPIN];
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign mode_o[i] = trig_e'(mode_q[i]);
    assign clr_o[i]  = wr_i && (addr_i == ADDR_STAT) && wdata_i[i];
  end

  always_comb begin
    ctrl_img = '0;
    ctrl_img[NPIN-1:0]         = en_q;
    ctrl_img[MODE_LSB +: NPIN] = mode_q;
    stat_img = '0;
    stat_img[NPIN-1:0] = pend_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= (addr_i == ADDR_STAT) ? stat_img : ctrl_img;
  end

  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int unsigned NPIN        = 2,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] irq_n_i,
  input  logic            imask_i,
  input  logic            vec_ack_i,
  input  logic            reg_wr_i,
  input  logic            reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            irq_req_o
);
  logic [NPIN-1:0] lvl_w;
  logic [NPIN-1:0] fall_w;
  logic [NPIN-1:0] pend_w;
  logic [NPIN-1:0] en_w;
  logic [NPIN-1:0] clr_w;
  logic [NPIN-1:0] edge_w;
  trig_e           mode_w [NPIN];
  logic            ctrl_wr_w;
  logic            req_q;

  xirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_i(irq_n_i), .sync_o(lvl_w)
  );

  xirq_regs #(.NPIN(NPIN), .DW(DW)) regs_i (
    .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .pend_i(pend_w), .en_o(en_w), .mode_o(mode_w),
    .clr_o(clr_w), .ctrl_wr_o(ctrl_wr_w), .rdata_o(reg_rdata_o)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    xirq_pin pin_i (
      .clk(clk), .rst(rst), .lvl_i(lvl_w[i]), .mode_i(mode_w[i]),
      .ack_i(vec_ack_i), .clr_i(clr_w[i]), .fall_o(fall_w[i]), .pend_o(pend_w[i])
    );
    assign edge_w[i] = (mode_w[i] == TRIG_EDGE);
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= ~imask_i & (|(en_w & pend_w));
  end

  assign irq_req_o = req_q;
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk #(
  parameter int unsigned NPIN = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            imask_i,
  input logic            vec_ack_i,
  input logic            irq_req_o,
  input logic [NPIN-1:0] en_w,
  input logic [NPIN-1:0] pend_w,
  input logic [NPIN-1:0] fall_w,
  input logic [NPIN-1:0] clr_w,
  input logic [NPIN-1:0] edge_w,
  input logic            ctrl_wr_w
);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !irq_req_o);

  a_r8_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    imask_i |=> !irq_req_o);

  a_r9_req_needs_enabled_pend: assert property (@(posedge clk) disable iff (rst)
    irq_req_o |-> $past(|(en_w & pend_w)));

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    a_r6_edge_captured: assert property (@(posedge clk) disable iff (rst)
      (edge_w[i] && fall_w[i] && !ctrl_wr_w) |=> pend_w[i]);

    a_r6_edge_held: assert property (@(posedge clk) disable iff (rst)
      (edge_w[i] && pend_w[i] && !vec_ack_i && !clr_w[i] && !ctrl_wr_w) |=> pend_w[i]);

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
      (edge_w[i] && vec_ack_i && !fall_w[i] && !ctrl_wr_w) |=> !pend_w[i]);

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
      (edge_w[i] && clr_w[i] && !fall_w[i] && !ctrl_wr_w) |=> !pend_w[i]);
  end
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NPIN(NPIN)) chk_i (
  .clk(clk), .rst(rst), .imask_i(imask_i), .vec_ack_i(vec_ack_i),
  .irq_req_o(irq_req_o), .en_w(en_w), .pend_w(pend_w), .fall_w(fall_w),
  .clr_w(clr_w), .edge_w(edge_w), .ctrl_wr_w(ctrl_wr_w)
);

// File: tb/xirq_ctrl_tb_top.sv
module xirq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] irq_n = 2'b11;
  logic       imask = 1'b1;
  logic       ack = 1'b0;
  logic       wr = 1'b0;
  logic       addr = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       req;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  typedef struct {
    bit         do_req;
    bit         req;
    bit         do_rd;
    logic [7:0] rd;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_n_i(irq_n), .imask_i(imask), .vec_ack_i(ack),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_req_o(req)
  );

  // monitor: compares one queued item per cycle, a quarter period after the edge
  initial forever begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      if (e.do_req) begin
        n_chk++;
        if (req !== e.req) begin
          n_fail++;
          $display("FAIL %s: irq_req_o=%0b expected %0b", e.tag, req, e.req);
        end
      end
      if (e.do_rd) begin
        n_chk++;
        if (rdata !== e.rd) begin
          n_fail++;
          $display("FAIL %s: reg_rdata_o=%02h expected %02h", e.tag, rdata, e.rd);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // push expectation for the next rising edge, then move to the next falling edge
  task automatic push(input bit dq, input bit q, input bit dr, input logic [7:0] r, input string t);
    exp_t e;
    e.do_req = dq; e.req = q; e.do_rd = dr; e.rd = r; e.tag = t;
    sb_q.push_back(e);
    tick(1);
  endtask

  task automatic chk_both(input bit q, input logic [7:0] r, input string t);
    push(1'b1, q, 1'b1, r, t);
  endtask
  task automatic chk_req(input bit q, input string t);
    push(1'b1, q, 1'b0, 8'h00, t);
  endtask
  task automatic chk_rd(input logic [7:0] r, input string t);
    push(1'b0, 1'b0, 1'b1, r, t);
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    chk_both(1'b0, 8'h00, "R1 reset status");
    addr = 1'b0;
    chk_rd(8'h00, "R1 reset control");

    // R2 control register layout
    wr_reg(1'b0, 8'hFF);
    chk_rd(8'h33, "R2 control readback all ones");
    wr_reg(1'b0, 8'h03);
    chk_rd(8'h03, "R2 control readback level mode");
    addr = 1'b1;

    // R3 level request persists while low
    imask = 1'b0;
    irq_n[0] = 1'b0;
    tick(2);
    chk_both(1'b1, 8'h01, "R3 level low requests");
    ack = 1'b1;
    chk_req(1'b1, "R3 request during ack");
    ack = 1'b0;
    chk_req(1'b1, "R3 repeats while low");
    irq_n[0] = 1'b1;
    tick(2);
    chk_both(1'b0, 8'h00, "R3 release drops request");

    // R8 / R4 masked level pulse
    imask = 1'b1;
    irq_n[1] = 1'b0;
    tick(2);
    chk_both(1'b0, 8'h02, "R8 masked level no request");
    irq_n[1] = 1'b1;
    tick(4);
    imask = 1'b0;
    tick(1);
    chk_both(1'b0, 8'h00, "R4 masked pulse forgotten");

    // R5 edge mode on pin0
    wr_reg(1'b0, 8'h13);
    addr = 1'b1;
    irq_n[0] = 1'b0;
    tick(2);
    chk_req(1'b0, "R5 edge not yet due");
    chk_both(1'b1, 8'h01, "R5 edge requests");
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    chk_both(1'b0, 8'h00, "R5 ack clears edge");
    tick(3);
    chk_req(1'b0, "R5 held low no second request");
    irq_n[0] = 1'b1;
    tick(3);

    // R6 masked edges, two pulses
    imask = 1'b1;
    irq_n[0] = 1'b0; tick(2); irq_n[0] = 1'b1; tick(3);
    irq_n[0] = 1'b0; tick(2); irq_n[0] = 1'b1; tick(3);
    chk_both(1'b0, 8'h01, "R8 masked edge held no request");
    imask = 1'b0;
    chk_req(1'b1, "R6 request on unmask");
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    chk_both(1'b0, 8'h00, "R6 single held edge serviced");
    tick(2);
    chk_req(1'b0, "R6 no second request");

    // R7 write-one-clear and ack clear
    imask = 1'b1;
    wr_reg(1'b0, 8'h33);
    addr = 1'b1;
    irq_n = 2'b00; tick(2); irq_n = 2'b11; tick(3);
    chk_rd(8'h03, "R7 both edges held");
    wr_reg(1'b1, 8'h01);
    chk_rd(8'h02, "R7 w1c clears pin0 only");
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    chk_rd(8'h00, "R7 ack clears all held edges");

    // R7 clear in the same cycle as a new edge
    irq_n[0] = 1'b0;
    tick(2);
    wr_reg(1'b1, 8'h01);
    chk_rd(8'h01, "R7 same-cycle edge survives clear");
    irq_n[0] = 1'b1;
    tick(3);
    wr_reg(1'b1, 8'h01);
    chk_rd(8'h00, "R7 later clear takes effect");

    // R9 disabled pin
    wr_reg(1'b0, 8'h01);
    addr = 1'b1;
    imask = 1'b0;
    irq_n[1] = 1'b0;
    tick(2);
    chk_both(1'b0, 8'h02, "R9 disabled pin flagged only");
    irq_n[1] = 1'b1;
    tick(3);

    // R8 mask drops an active request
    irq_n[0] = 1'b0;
    tick(2);
    chk_req(1'b1, "R3 enabled level pin0");
    imask = 1'b1;
    chk_req(1'b0, "R8 mask drops request");
    irq_n[0] = 1'b1;
    tick(4);
    summary();
  end
endmodule